// File: doc/BRIEF.md
# Beam-Synchronised Register-Write Coprocessor

This block is a small list-executing coprocessor that runs alongside a video beam counter. It reads a list of two-word instructions from memory through a simple combinational read port and uses them to drive a register write bus. The list runs on its own, with no processor involved. Each instruction does one of three things. It can write a data word to a register address. It can stall until the beam reaches a programmed position. It can skip the following instruction if the beam has already passed a programmed position.

The sequencer has exactly three states: fetch first word, fetch second word, and hold for beam. The list can write two internal registers: a jump-target pointer and a jump strobe. This lets a list build jumps and loops. A restart strobe, typically pulsed once per frame, sends execution back to the list start pointer. Writes to low register addresses are dropped unless a danger-enable input is high. A list normally ends with a wait on a beam position that is never reached, such as vertical 0xFF and horizontal 0x7F with full masks.

Top module: `beamlist_engine`

## Requirements
- R1: Synchronous active-high reset clears `wr_en` and loads the fetch address `mem_addr` from `list_start`. Fetching begins on the first clock after reset is released.
- R2: An instruction is two 16-bit words. A first word with bit 0 clear is a move: bits [8:1] give the register address and the second word is the data. The write appears as a one-cycle `wr_en` pulse on the clock after the second word is fetched, and moves are issued in list order.
- R3: A first word with bit 0 set is a beam condition. Its bits [15:8] hold the vertical target and bits [7:1] the horizontal target. In the second word, bits [15:8] are the vertical mask, bits [7:1] the horizontal mask, and bit 0 clear means wait. A wait holds execution until the masked {vertical, horizontal} beam position is at or above the masked target, with vertical as the more significant part.
- R4: A mask bit that is clear removes the matching beam bit and target bit from the comparison.
- R5: A condition whose second-word bit 0 is set is a skip. If the condition holds when the skip is decoded, the next two-word instruction is not executed. Otherwise execution continues normally.
- R6: A move to a register address below PROT_LIMIT (default 0x20) produces no write unless `danger_en` is high.
- R7: A move to address 0x7E loads the jump target. A move to 0x7F makes the next fetch come from the jump target. Neither address ever appears on the write bus.
- R8: A `restart` pulse takes priority over everything. On the next clock the fetch address becomes `list_start` and any pending wait is abandoned.
- R9: The sequencer only uses its three states. Because each move takes two fetch cycles, `wr_en` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beam_v | input | 8 | Current vertical beam position |
| beam_h | input | 7 | Current horizontal beam position |
| list_start | input | ADDR_W | Word address where the list begins |
| restart | input | 1 | Reload the fetch address from `list_start` |
| danger_en | input | 1 | Allow writes to protected low addresses |
| mem_addr | output | ADDR_W | Word address being read |
| mem_rdata | input | 16 | Word at `mem_addr`, valid in the same cycle |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | REG_AW | Register address of the write |
| wr_data | output | 16 | Data of the write |

## Verification
The bench targets several corner cases, each with a known failure mode:
- A beam exactly at the wait target. An off-by-one compare that tests for strictly greater would stall there.
- A beam whose vertical position is past the target while its horizontal position is below it. A compare that treats the two axes separately would stall there.
- Masked-out bits that differ between beam and target. Ignoring the masks would block the wait.
- A skip in both its taken and not-taken forms. A wrong skip distance would drop or repeat the wrong move.
- The protection threshold with `danger_en` low and high, a jump through the internal pointer registers whose writes must not reach the bus, and a restart issued while the list is stalled on an unreachable position. A missing restart priority would leave the machine hung there.

// File: rtl/beamlist_pkg.sv
package beamlist_pkg;

    localparam int WORD_W = 16;
    localparam int VPOS_W = 8;
    localparam int HPOS_W = 7;
    localparam int BEAM_W = VPOS_W + HPOS_W;

    typedef enum logic [1:0] {
        ST_FETCH_A = 2'd0,
        ST_FETCH_B = 2'd1,
        ST_HOLD    = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_MOVE = 2'd0,
        OP_WAIT = 2'd1,
        OP_SKIP = 2'd2
    } op_kind_t;

    typedef struct packed {
        logic [VPOS_W-1:0] v;
        logic [HPOS_W-1:0] h;
    } beam_pos_t;

    typedef struct packed {
        beam_pos_t target;
        beam_pos_t mask;
    } beam_cond_t;

    function automatic op_kind_t classify(input logic [WORD_W-1:0] w1,
                                          input logic [WORD_W-1:0] w2);
        if (!w1[0])
            return OP_MOVE;
        else if (w2[0])
            return OP_SKIP;
        else
            return OP_WAIT;
    endfunction

    function automatic logic pos_reached(input beam_pos_t cur,
                                         input beam_cond_t cond);
        logic [BEAM_W-1:0] lhs;
        logic [BEAM_W-1:0] rhs;
        lhs = cur & cond.mask;
        rhs = cond.target & cond.mask;
        return lhs >= rhs;
    endfunction

endpackage

// File: rtl/bl_decode.sv
module bl_decode
    import beamlist_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output op_kind_t          op,
    output beam_cond_t        cond,
    output logic [REG_AW-1:0] reg_addr,
    output logic [WORD_W-1:0] data
);
    always_comb begin
        op          = classify(word_a, word_b);
        cond.target = beam_pos_t'(word_a[WORD_W-1:1]);
        cond.mask   = beam_pos_t'(word_b[WORD_W-1:1]);
        reg_addr    = word_a[REG_AW:1];
        data        = word_b;
    end
endmodule

// File: rtl/bl_beam_cmp.sv
module bl_beam_cmp
    import beamlist_pkg::*;
(
    input  logic [VPOS_W-1:0] beam_v,
    input  logic [HPOS_W-1:0] beam_h,
    input  beam_cond_t        cond,
    output logic              hit
);
    beam_pos_t cur;

    always_comb begin
        cur.v = beam_v;
        cur.h = beam_h;
        hit   = pos_reached(cur, cond);
    end
endmodule

// File: rtl/bl_write_gate.sv
module bl_write_gate #(
    parameter int unsigned REG_AW     = 8,
    parameter int unsigned PROT_LIMIT = 32,
    parameter int unsigned PTR_REG    = 126,
    parameter int unsigned JUMP_REG   = 127
) (
    input  logic              fire,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              danger_en,
    output logic              ext_wr,
    output logic              ptr_wr,
    output logic              jump_wr
);
    localparam logic [REG_AW-1:0] LIMIT_A = REG_AW'(PROT_LIMIT);
    localparam logic [REG_AW-1:0] PTR_A   = REG_AW'(PTR_REG);
    localparam logic [REG_AW-1:0] JUMP_A  = REG_AW'(JUMP_REG);

    logic is_ptr;
    logic is_jump;
    logic allowed;

    always_comb begin
        is_ptr  = (reg_addr == PTR_A);
        is_jump = (reg_addr == JUMP_A);
        allowed = (reg_addr >= LIMIT_A) || danger_en;
        ptr_wr  = fire && is_ptr;
        jump_wr = fire && is_jump;
        ext_wr  = fire && !is_ptr && !is_jump && allowed;
    end
endmodule

// File: rtl/bl_sequencer.sv
module bl_sequencer
    import beamlist_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [ADDR_W-1:0] list_start,
    input  logic [WORD_W-1:0] rdata,
    input  op_kind_t          op,
    input  beam_cond_t        cond_dec,
    input  logic              hit,
    input  logic              ptr_wr,
    input  logic              jump_wr,
    input  logic [WORD_W-1:0] move_data,
    output seq_state_t        state,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] word_a,
    output beam_cond_t        cond_held
);
    localparam logic [ADDR_W-1:0] STEP_ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_SKIP = ADDR_W'(3);

    logic [ADDR_W-1:0] jump_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_FETCH_A;
            pc        <= list_start;
            word_a    <= '0;
            cond_held <= '0;
            jump_ptr  <= '0;
        end else if (restart) begin
            state <= ST_FETCH_A;
            pc    <= list_start;
        end else begin
            unique case (state)
                ST_FETCH_A: begin
                    word_a <= rdata;
                    pc     <= pc + STEP_ONE;
                    state  <= ST_FETCH_B;
                end
                ST_FETCH_B: begin
                    unique case (op)
                        OP_MOVE: begin
                            state <= ST_FETCH_A;
                            if (jump_wr)
                                pc <= jump_ptr;
                            else
                                pc <= pc + STEP_ONE;
                            if (ptr_wr)
                                jump_ptr <= ADDR_W'(move_data);
                        end
                        OP_WAIT: begin
                            cond_held <= cond_dec;
                            pc        <= pc + STEP_ONE;
                            state     <= ST_HOLD;
                        end
                        OP_SKIP: begin
                            pc    <= hit ? pc + STEP_SKIP : pc + STEP_ONE;
                            state <= ST_FETCH_A;
                        end
                        default: state <= ST_FETCH_A;
                    endcase
                end
                ST_HOLD: begin
                    if (hit)
                        state <= ST_FETCH_A;
                end
                default: state <= ST_FETCH_A;
            endcase
        end
    end
endmodule

// File: rtl/beamlist_engine.sv
module beamlist_engine
    import beamlist_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          REG_AW     = 8,
    parameter int unsigned PROT_LIMIT = 32,
    parameter int unsigned PTR_REG    = 126,
    parameter int unsigned JUMP_REG   = 127
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        beam_v,
    input  logic [6:0]        beam_h,
    input  logic [ADDR_W-1:0] list_start,
    input  logic              restart,
    input  logic              danger_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_rdata,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [15:0]       wr_data
);
    seq_state_t        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [WORD_W-1:0] word_a_q;
    beam_cond_t        cond_held;
    beam_cond_t        cond_dec;
    beam_cond_t        cond_sel;
    op_kind_t          op_dec;
    logic [REG_AW-1:0] reg_addr_dec;
    logic [WORD_W-1:0] data_dec;
    logic              cmp_hit;
    logic              move_fire;
    logic              ext_wr;
    logic              ptr_wr;
    logic              jump_wr;

    bl_decode #(.REG_AW(REG_AW)) u_dec (
        .word_a   (word_a_q),
        .word_b   (mem_rdata),
        .op       (op_dec),
        .cond     (cond_dec),
        .reg_addr (reg_addr_dec),
        .data     (data_dec)
    );

    assign cond_sel = (state_q == ST_HOLD) ? cond_held : cond_dec;

    bl_beam_cmp u_cmp (
        .beam_v (beam_v),
        .beam_h (beam_h),
        .cond   (cond_sel),
        .hit    (cmp_hit)
    );

    assign move_fire = (state_q == ST_FETCH_B) && (op_dec == OP_MOVE) && !restart;

    bl_write_gate #(
        .REG_AW     (REG_AW),
        .PROT_LIMIT (PROT_LIMIT),
        .PTR_REG    (PTR_REG),
        .JUMP_REG   (JUMP_REG)
    ) u_gate (
        .fire      (move_fire),
        .reg_addr  (reg_addr_dec),
        .danger_en (danger_en),
        .ext_wr    (ext_wr),
        .ptr_wr    (ptr_wr),
        .jump_wr   (jump_wr)
    );

    bl_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .list_start (list_start),
        .rdata      (mem_rdata),
        .op         (op_dec),
        .cond_dec   (cond_dec),
        .hit        (cmp_hit),
        .ptr_wr     (ptr_wr),
        .jump_wr    (jump_wr),
        .move_data  (data_dec),
        .state      (state_q),
        .pc         (pc_q),
        .word_a     (word_a_q),
        .cond_held  (cond_held)
    );

    assign mem_addr = pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= ext_wr;
            if (ext_wr) begin
                wr_addr <= reg_addr_dec;
                wr_data <= data_dec;
            end
        end
    end
endmodule

// File: rtl/bl_checker.sv
module bl_checker
    import beamlist_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          REG_AW     = 8,
    parameter int unsigned PROT_LIMIT = 32,
    parameter int unsigned PTR_REG    = 126,
    parameter int unsigned JUMP_REG   = 127
) (
    input logic              clk,
    input logic              rst,
    input logic              restart,
    input logic              danger_en,
    input logic [ADDR_W-1:0] list_start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input seq_state_t        state,
    input logic              hit
);
    // R8: restart reloads the fetch address on the next clock
    a_r8_restart_load: assert property (@(posedge clk) disable iff (rst)
        restart |=> (mem_addr == $past(list_start)));

    // R6: protected addresses only leave the block while danger_en was high
    a_r6_protect: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_addr >= REG_AW'(PROT_LIMIT)) || $past(danger_en)));

    // R7: internal jump registers never reach the bus
    a_r7_self_hidden: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_addr != REG_AW'(PTR_REG)) && (wr_addr != REG_AW'(JUMP_REG))));

    // R9: no back-to-back writes
    a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R9: only the three defined states are used
    a_r9_legal_state: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_A) || (state == ST_FETCH_B) || (state == ST_HOLD));

    // R3: an unmet wait keeps the machine parked without fetching
    a_r3_hold_parked: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_HOLD) && !hit && !restart) |=>
            ((state == ST_HOLD) && $stable(mem_addr) && !wr_en));
endmodule

bind beamlist_engine bl_checker #(
    .ADDR_W     (ADDR_W),
    .REG_AW     (REG_AW),
    .PROT_LIMIT (PROT_LIMIT),
    .PTR_REG    (PTR_REG),
    .JUMP_REG   (JUMP_REG)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .danger_en  (danger_en),
    .list_start (list_start),
    .mem_addr   (mem_addr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .state      (state_q),
    .hit        (cmp_hit)
);

// File: tb/tb_beamlist_engine.sv
module tb_beamlist_engine;
    localparam int AW = 8;
    localparam int WD_LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    beam_v = '0;
    logic [6:0]    beam_h = '0;
    logic [AW-1:0] list_start = '0;
    logic          restart = 1'b0;
    logic          danger_en = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_rdata;
    logic          wr_en;
    logic [7:0]    wr_addr;
    logic [15:0]   wr_data;

    logic [15:0] mem [0:(1<<AW)-1];

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int n_log = 0;
    logic [7:0]  log_addr [0:15];
    logic [15:0] log_data [0:15];
    int          log_cyc  [0:15];

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    beamlist_engine #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .beam_v(beam_v), .beam_h(beam_h),
        .list_start(list_start), .restart(restart), .danger_en(danger_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            failures = failures + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst && wr_en && n_log < 16) begin
            log_addr[n_log] = wr_addr;
            log_data[n_log] = wr_data;
            log_cyc[n_log]  = cyc;
            n_log = n_log + 1;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_move(input logic [7:0] a, input logic [15:0] d);
        return {7'b0, a, 1'b0, d};
    endfunction

    function automatic logic [31:0] enc_cond(input logic [7:0] v, input logic [6:0] h,
                                             input logic [7:0] vm, input logic [6:0] hm,
                                             input logic is_skip);
        return {v, h, 1'b1, vm, hm, is_skip};
    endfunction

    task automatic put(input int addr, input logic [31:0] ins);
        mem[addr]   = ins[31:16];
        mem[addr+1] = ins[15:0];
    endtask

    task automatic put_end(input int addr);
        put(addr, enc_cond(8'hFF, 7'h7F, 8'hFF, 7'h7F, 1'b0));
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_list(input int base);
        @(negedge clk);
        n_log = 0;
        list_start = AW'(base);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic t_reset;
        check(mem_addr == '0, "R1 fetch address after reset", int'(mem_addr), 0);
        check(wr_en == 1'b0, "R1 wr_en after reset", int'(wr_en), 0);
        run(10);
        check(n_log == 0, "R1 no writes from idle list", n_log, 0);
    endtask

    task automatic t_moves;
        put(16, enc_move(8'h30, 16'h1234));
        put(18, enc_move(8'h45, 16'hABCD));
        put_end(20);
        start_list(16);
        run(12);
        check(n_log == 2, "R2 move count", n_log, 2);
        check(log_addr[0] == 8'h30 && log_data[0] == 16'h1234, "R2 first move",
              int'(log_data[0]), 16'h1234);
        check(log_addr[1] == 8'h45 && log_data[1] == 16'hABCD, "R2 second move",
              int'(log_data[1]), 16'hABCD);
        check(log_cyc[1] - log_cyc[0] == 2, "R9 move spacing",
              log_cyc[1] - log_cyc[0], 2);
    endtask

    task automatic t_wait;
        put(40, enc_cond(8'h10, 7'h05, 8'hFF, 7'h7F, 1'b0));
        put(42, enc_move(8'h30, 16'h0001));
        put_end(44);
        beam_v = 8'h10; beam_h = 7'h04;
        start_list(40);
        run(20);
        check(n_log == 0, "R3 wait holds below target", n_log, 0);
        beam_h = 7'h05;
        run(8);
        check(n_log == 1, "R3 wait releases at exact target", n_log, 1);
        beam_v = 8'h11; beam_h = 7'h00;
        start_list(40);
        run(10);
        check(n_log == 1, "R3 vertical past target with low horizontal", n_log, 1);
        beam_v = 8'h00; beam_h = 7'h00;
    endtask

    task automatic t_mask;
        put(60, enc_cond(8'h80, 7'h7E, 8'h80, 7'h00, 1'b0));
        put(62, enc_move(8'h31, 16'h00C3));
        put_end(64);
        beam_v = 8'h7F; beam_h = 7'h7E;
        start_list(60);
        run(15);
        check(n_log == 0, "R4 masked wait holds", n_log, 0);
        beam_v = 8'h80; beam_h = 7'h00;
        run(8);
        check(n_log == 1 && log_data[0] == 16'h00C3, "R4 masked bits ignored", n_log, 1);
        beam_v = 8'h00;
    endtask

    task automatic t_skip;
        put(80, enc_cond(8'h20, 7'h00, 8'hFF, 7'h7F, 1'b1));
        put(82, enc_move(8'h30, 16'hAAAA));
        put(84, enc_move(8'h31, 16'hBBBB));
        put_end(86);
        beam_v = 8'h30;
        start_list(80);
        run(15);
        check(n_log == 1, "R5 skip taken count", n_log, 1);
        check(log_addr[0] == 8'h31 && log_data[0] == 16'hBBBB, "R5 skip taken target",
              int'(log_data[0]), 16'hBBBB);
        beam_v = 8'h10;
        start_list(80);
        run(15);
        check(n_log == 2, "R5 skip not taken count", n_log, 2);
        check(log_data[0] == 16'hAAAA, "R5 skip not taken order", int'(log_data[0]), 16'hAAAA);
        beam_v = 8'h00;
    endtask

    task automatic t_protect;
        put(100, enc_move(8'h05, 16'h0055));
        put(102, enc_move(8'h1F, 16'h001F));
        put(104, enc_move(8'h20, 16'h0066));
        put_end(106);
        danger_en = 1'b0;
        start_list(100);
        run(15);
        check(n_log == 1, "R6 protected writes dropped", n_log, 1);
        check(log_addr[0] == 8'h20, "R6 threshold address passes", int'(log_addr[0]), 8'h20);
        danger_en = 1'b1;
        start_list(100);
        run(15);
        check(n_log == 3, "R6 danger enable passes all", n_log, 3);
        check(log_addr[0] == 8'h05, "R6 low address with danger", int'(log_addr[0]), 5);
        danger_en = 1'b0;
    endtask

    task automatic t_jump;
        put(160, enc_move(8'h7E, 16'd200));
        put(162, enc_move(8'h7F, 16'h0000));
        put(164, enc_move(8'h30, 16'h0001));
        put_end(166);
        put(200, enc_move(8'h32, 16'h0007));
        put_end(202);
        start_list(160);
        run(16);
        check(n_log == 1, "R7 jump write count", n_log, 1);
        check(log_addr[0] == 8'h32 && log_data[0] == 16'h0007, "R7 jump target executed",
              int'(log_addr[0]), 8'h32);
    endtask

    task automatic t_restart;
        put_end(120);
        put(122, enc_move(8'h30, 16'h0009));
        put(130, enc_move(8'h33, 16'h0077));
        put_end(132);
        start_list(120);
        run(12);
        check(n_log == 0, "R8 parked on unreachable wait", n_log, 0);
        @(negedge clk);
        list_start = AW'(130);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        n_log = 0;
        check(mem_addr == AW'(130), "R8 restart reload address", int'(mem_addr), 130);
        run(8);
        check(n_log == 1 && log_addr[0] == 8'h33, "R8 list runs after restart",
              int'(log_addr[0]), 8'h33);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++)
            mem[i] = i[0] ? 16'hFFFE : 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_moves();
        t_wait();
        t_mask();
        t_skip();
        t_protect();
        t_jump();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule